// File: doc/BRIEF.md
# Index/Data Port Register Bridge

This block gives a host that only has two byte-wide I/O ports (an index port and a data port) a way to issue full 32-bit reads and writes on an internal register bus. The host writes a register number to the index port. It then reads or writes that register through the data port. The bridge's registers stay out of reach until the host writes a key byte to the index port twice in a row. They also stay out of reach until the host selects the bridge's logical device number.

Once the host has access, it fills four address bytes and four data bytes and confirms a word-sized access length. It then fires a trigger register. A magic byte written to the trigger starts a bus write. A read of the trigger starts a bus read, and the returned word lands in the data bytes. The internal bus is a plain request/acknowledge port. The request and its attributes are held steady until the acknowledge arrives. While a transfer is in flight, the bridge refuses new triggers and changes to its transfer registers.

Top module: `idx_bus_bridge`

## Requirements
- R1: After reset the bridge is locked. While locked, every port read returns 0xFF, data-port writes have no effect and no bus request is made. It unlocks once 0xA5 has been written to the index port on two consecutive index writes. Reset also clears the address bytes to 0.
- R2: While locked, an index write of any byte other than 0xA5 discards a single pending 0xA5. Neither key byte changes the selected register number.
- R3: While unlocked, an index write of 0xAA locks the bridge again and leaves the selected register number unchanged.
- R4: While unlocked, an index write selects a register number and data-port accesses read or write that register. An index-port read returns the selected number. Unimplemented registers read as 0x00.
- R5: Register 0x07 holds the logical device number and is always reachable while unlocked. Registers 0x30 and 0xF0 to 0xFE respond only while it holds 0x0D. Otherwise they read 0xFF and ignore writes.
- R6: Bit 0 of register 0x30 enables the bridge and reads back as {7'b0, enable}. While it is clear, both triggers are ignored.
- R7: bus_addr carries registers 0xF0 (bits 31:24) down to 0xF3 (bits 7:0). bus_wdata carries 0xF4 (bits 7:0) up to 0xF7 (bits 31:24).
- R8: Writing 0xCF to register 0xFE starts a bus write: bus_req and bus_we are high from the next cycle. Any other value written there does nothing.
- R9: Reading register 0xFE starts a bus read (bus_we low). The read returns {7'b0, busy} as it was before the access. The acknowledged bus_rdata is loaded into 0xF4 to 0xF7 in the same byte order as R7.
- R10: Register 0xF8 resets to 0x02. A trigger starts a transfer only while it holds 0x02.
- R11: xfer_busy is high from the trigger until the acknowledge. While it is high, triggers are ignored, writes to 0xF0 to 0xF8 are ignored and reads of 0xF4 to 0xF7 return their previous contents.
- R12: bus_req stays high with bus_addr, bus_we and bus_wdata unchanged until bus_ack, and it drops in the cycle after bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | One-cycle write strobe for the selected port |
| io_rd | input | 1 | One-cycle read strobe for the selected port |
| io_sel | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | Byte written to the port |
| io_rdata | output | 8 | Byte read, valid from the cycle after io_rd |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | output | 32 | Internal bus address |
| bus_wdata | output | 32 | Internal bus write word |
| bus_rdata | input | 32 | Internal bus read word, taken with bus_ack |
| bus_ack | input | 1 | Internal bus acknowledge, one cycle |
| xfer_busy | output | 1 | A transfer is pending |

## Verification
The hardest condition to reach from the ports is host traffic arriving while a transfer is still in flight. This covers stale reads of the data bytes, a second trigger, the status read of the trigger register and writes to the address bytes. The bench's bus responder holds its acknowledge back for a programmable number of cycles. It stretches that latency far enough that a whole burst of index and data accesses fits inside one pending transfer. The bench then counts acknowledges to prove that no extra transfer was started.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam logic [7:0] KEY_BYTE    = 8'hA5;
  localparam logic [7:0] RELOCK_BYTE = 8'hAA;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ENA     = 8'h30;
  localparam logic [7:0] REG_ADDR0   = 8'hF0;
  localparam logic [7:0] REG_DATA0   = 8'hF4;
  localparam logic [7:0] REG_LEN     = 8'hF8;
  localparam logic [7:0] REG_TRIG    = 8'hFE;
  localparam logic [7:0] TRIG_MAGIC  = 8'hCF;
  localparam logic [7:0] LDN_BRIDGE  = 8'h0D;
  localparam logic [7:0] LEN_WORD    = 8'h02;
  localparam logic [7:0] RD_FLOAT    = 8'hFF;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_st_e;
endpackage

// File: rtl/brg_key_gate.sv
module brg_key_gate
  import brg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wbyte,
  output logic       key_open
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr) begin
      case (st_q)
        KEY_LOCKED: st_d = (wbyte == KEY_BYTE) ? KEY_HALF : KEY_LOCKED;
        KEY_HALF:   st_d = (wbyte == KEY_BYTE) ? KEY_OPEN : KEY_LOCKED;
        KEY_OPEN:   st_d = (wbyte == RELOCK_BYTE) ? KEY_LOCKED : KEY_OPEN;
        default:    st_d = KEY_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_LOCKED;
    else        st_q <= st_d;
  end

  assign key_open = (st_q == KEY_OPEN);
endmodule

// File: rtl/brg_bus_ctl.sv
module brg_bus_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_wr,
  input  logic launch_rd,
  input  logic bus_ack,
  output logic busy,
  output logic we,
  output logic ld_rd
);
  logic busy_q, busy_d;
  logic we_q, we_d;

  always_comb begin
    busy_d = busy_q;
    we_d   = we_q;
    if (busy_q) begin
      if (bus_ack) busy_d = 1'b0;
    end else if (launch_wr || launch_rd) begin
      busy_d = 1'b1;
      we_d   = launch_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      we_q   <= we_d;
    end
  end

  assign busy  = busy_q;
  assign we    = we_q;
  assign ld_rd = busy_q && bus_ack && !we_q;
endmodule

// File: rtl/brg_cfg_regs.sv
module brg_cfg_regs
  import brg_pkg::*;
#(
  parameter int AB = 4,
  parameter int DB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            key_open,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic            io_sel,
  input  logic [7:0]      io_wdata,
  input  logic            busy,
  input  logic            ld_rd,
  input  logic [DB*8-1:0] bus_rdata,
  output logic [7:0]      io_rdata,
  output logic [AB*8-1:0] addr_o,
  output logic [DB*8-1:0] data_o,
  output logic            launch_wr,
  output logic            launch_rd,
  output logic            ena_o
);
  logic [7:0] idx_q, idx_d;
  logic [7:0] ldn_q, ldn_d;
  logic [7:0] len_q, len_d;
  logic [7:0] rdat_q, rdat_d;
  logic       ena_q, ena_d;
  logic [7:0] rd_val;
  logic       idx_wr, dat_wr, dat_rd, dev_sel, dev_wr, cfg_wr_ok, trig_ok;

  assign idx_wr    = io_wr && !io_sel && key_open && (io_wdata != RELOCK_BYTE);
  assign dat_wr    = io_wr && io_sel && key_open;
  assign dat_rd    = io_rd && io_sel && key_open;
  assign dev_sel   = (ldn_q == LDN_BRIDGE);
  assign dev_wr    = dat_wr && dev_sel;
  assign cfg_wr_ok = dev_wr && !busy;
  assign trig_ok   = ena_q && !busy && (len_q == LEN_WORD) && dev_sel && (idx_q == REG_TRIG);
  assign launch_wr = dat_wr && trig_ok && (io_wdata == TRIG_MAGIC);
  assign launch_rd = dat_rd && trig_ok;

  always_comb begin
    idx_d = idx_wr ? io_wdata : idx_q;
    ldn_d = (dat_wr && idx_q == REG_LDN) ? io_wdata : ldn_q;
    ena_d = (dev_wr && idx_q == REG_ENA) ? io_wdata[0] : ena_q;
    len_d = (cfg_wr_ok && idx_q == REG_LEN) ? io_wdata : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
      ena_q <= 1'b0;
      len_q <= LEN_WORD;
    end else begin
      idx_q <= idx_d;
      ldn_q <= ldn_d;
      ena_q <= ena_d;
      len_q <= len_d;
    end
  end

  // address bytes: lowest register number is the most significant byte
  for (genvar k = 0; k < AB; k++) begin : g_addr
    localparam logic [7:0] RNUM = REG_ADDR0 + 8'(k);
    logic [7:0] byte_q, byte_d;
    always_comb byte_d = (cfg_wr_ok && idx_q == RNUM) ? io_wdata : byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= 8'h00;
      else        byte_q <= byte_d;
    end
    assign addr_o[8*(AB-1-k) +: 8] = byte_q;
  end

  // data bytes: lowest register number is the least significant byte
  for (genvar k = 0; k < DB; k++) begin : g_data
    localparam logic [7:0] RNUM = REG_DATA0 + 8'(k);
    logic [7:0] byte_q, byte_d;
    always_comb begin
      byte_d = byte_q;
      if (ld_rd)                            byte_d = bus_rdata[8*k +: 8];
      else if (cfg_wr_ok && idx_q == RNUM)  byte_d = io_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= 8'h00;
      else        byte_q <= byte_d;
    end
    assign data_o[8*k +: 8] = byte_q;
  end

  always_comb begin
    rd_val = 8'h00;
    if (!key_open)              rd_val = RD_FLOAT;
    else if (!io_sel)           rd_val = idx_q;
    else if (idx_q == REG_LDN)  rd_val = ldn_q;
    else if (!dev_sel)          rd_val = RD_FLOAT;
    else begin
      if (idx_q == REG_ENA)  rd_val = {7'b0, ena_q};
      if (idx_q == REG_LEN)  rd_val = len_q;
      if (idx_q == REG_TRIG) rd_val = {7'b0, busy};
      for (int k = 0; k < AB; k++)
        if (idx_q == REG_ADDR0 + 8'(k)) rd_val = addr_o[8*(AB-1-k) +: 8];
      for (int k = 0; k < DB; k++)
        if (idx_q == REG_DATA0 + 8'(k)) rd_val = data_o[8*k +: 8];
    end
  end

  always_comb rdat_d = io_rd ? rd_val : rdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdat_q <= RD_FLOAT;
    else        rdat_q <= rdat_d;
  end

  assign io_rdata = rdat_q;
  assign ena_o    = ena_q;
endmodule

// File: rtl/idx_bus_bridge.sv
module idx_bus_bridge
  import brg_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    io_wr,
  input  logic                    io_rd,
  input  logic                    io_sel,
  input  logic [7:0]              io_wdata,
  output logic [7:0]              io_rdata,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [ADDR_BYTES*8-1:0] bus_addr,
  output logic [DATA_BYTES*8-1:0] bus_wdata,
  input  logic [DATA_BYTES*8-1:0] bus_rdata,
  input  logic                    bus_ack,
  output logic                    xfer_busy
);
  localparam int AW = ADDR_BYTES * 8;
  localparam int DW = DATA_BYTES * 8;

  logic rst_meta_n, rst_core_n;
  logic key_open, ena_bit, busy, we, ld_rd, launch_wr, launch_rd, idx_wr_raw;
  logic [AW-1:0] addr_w;
  logic [DW-1:0] data_w;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  assign idx_wr_raw = io_wr && !io_sel;

  brg_key_gate u_key (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .idx_wr   (idx_wr_raw),
    .wbyte    (io_wdata),
    .key_open (key_open)
  );

  brg_cfg_regs #(.AB(ADDR_BYTES), .DB(DATA_BYTES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .key_open  (key_open),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_sel    (io_sel),
    .io_wdata  (io_wdata),
    .busy      (busy),
    .ld_rd     (ld_rd),
    .bus_rdata (bus_rdata),
    .io_rdata  (io_rdata),
    .addr_o    (addr_w),
    .data_o    (data_w),
    .launch_wr (launch_wr),
    .launch_rd (launch_rd),
    .ena_o     (ena_bit)
  );

  brg_bus_ctl u_bus (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .launch_wr (launch_wr),
    .launch_rd (launch_rd),
    .bus_ack   (bus_ack),
    .busy      (busy),
    .we        (we),
    .ld_rd     (ld_rd)
  );

  assign bus_req   = busy;
  assign bus_we    = we;
  assign bus_addr  = addr_w;
  assign bus_wdata = data_w;
  assign xfer_busy = busy;
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          io_rd,
  input logic [7:0]    io_rdata,
  input logic          key_open,
  input logic          ena_bit
);
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req);

  a_r12_attr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r12_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);

  a_r1_no_launch_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(key_open));

  a_r1_locked_read_float: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && !key_open |=> io_rdata == 8'hFF);

  a_r6_launch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(ena_bit));
endmodule

bind idx_bus_bridge brg_checker #(.AW(ADDR_BYTES*8), .DW(DATA_BYTES*8)) u_brg_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .io_rd     (io_rd),
  .io_rdata  (io_rdata),
  .key_open  (key_open),
  .ena_bit   (ena_bit)
);

// File: tb/test_idx_bus_bridge.sv
module test_idx_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0, io_rd = 1'b0, io_sel = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        bus_req, bus_we, bus_ack, xfer_busy;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ack_dly = 3, dly_cnt = 0, ack_cnt = 0;
  logic        cap_we;
  logic [31:0] cap_addr, cap_wdata;
  logic [31:0] rsp_word = 32'h0;

  always #4 clk = ~clk;

  idx_bus_bridge i_idx_bus_bridge (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .xfer_busy(xfer_busy)
  );

  assign bus_rdata = rsp_word;

  // bus responder with programmable acknowledge latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      dly_cnt <= 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      if (dly_cnt >= ack_dly) begin
        bus_ack   <= 1'b1;
        dly_cnt   <= 0;
        ack_cnt   <= ack_cnt + 1;
        cap_we    <= bus_we;
        cap_addr  <= bus_addr;
        cap_wdata <= bus_wdata;
      end else begin
        dly_cnt <= dly_cnt + 1;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_sel = sel; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_sel = sel;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic rd_chk(input logic sel, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    io_read(sel, v);
    chk(v == exp, tag, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
    io_write(1'b0, r);
    io_write(1'b1, d);
  endtask

  task automatic reg_chk(input logic [7:0] r, input logic [7:0] exp, input string tag);
    io_write(1'b0, r);
    rd_chk(1'b1, exp, tag);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!xfer_busy) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // {kind[1:0], sel, byte}: kind 0 = write, 1 = read and compare
  localparam int NV = 34;
  localparam logic [10:0] VEC [NV] = '{
    11'h2FF,                            // locked index read
    11'h0A5, 11'h0A5,                   // key
    11'h007, 11'h10D, 11'h30D, 11'h207, // device number
    11'h030, 11'h101, 11'h301,          // enable
    11'h0F0, 11'h112, 11'h0F1, 11'h134, 11'h0F2, 11'h156, 11'h0F3, 11'h178,
    11'h0F4, 11'h1EF, 11'h0F5, 11'h1BE, 11'h0F6, 11'h1AD, 11'h0F7, 11'h1DE,
    11'h0F8, 11'h302,                   // length reset value
    11'h0F2, 11'h356, 11'h0F5, 11'h3BE,
    11'h0C0, 11'h300                    // unimplemented register
  };

  initial begin
    logic [7:0] v;
    do_reset();
    chk(bus_req == 1'b0, "R1 reset req", {31'h0, bus_req}, 32'h0);
    chk(xfer_busy == 1'b0, "R1 reset busy", {31'h0, xfer_busy}, 32'h0);
    rd_chk(1'b1, 8'hFF, "R1 locked data read");
    io_write(1'b1, 8'h07);
    chk(bus_req == 1'b0, "R1 locked write no req", {31'h0, bus_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][9]) begin
        io_read(VEC[i][8], v);
        chk(v == VEC[i][7:0], (i == 0) ? "R1 table" : "R4 table", {24'h0, v}, {24'h0, VEC[i][7:0]});
      end else begin
        io_write(VEC[i][8], VEC[i][7:0]);
      end
    end
    chk(bus_addr == 32'h12345678, "R7 address order", bus_addr, 32'h12345678);
    chk(bus_wdata == 32'hDEADBEEF, "R7 data order", bus_wdata, 32'hDEADBEEF);

    // R8 write trigger
    ack_dly = 3;
    reg_wr(8'hFE, 8'h11);
    repeat (3) @(negedge clk);
    chk(!xfer_busy && ack_cnt == 0, "R8 non-magic value", ack_cnt, 0);
    io_write(1'b1, 8'hCF);
    chk(xfer_busy == 1'b1, "R8 busy after magic", {31'h0, xfer_busy}, 1);
    chk(bus_we == 1'b1, "R8 write direction", {31'h0, bus_we}, 1);
    wait_idle();
    chk(ack_cnt == 1, "R8 one transfer", ack_cnt, 1);
    chk(cap_we == 1'b1 && cap_addr == 32'h12345678, "R12 write addr", cap_addr, 32'h12345678);
    chk(cap_wdata == 32'hDEADBEEF, "R12 write data", cap_wdata, 32'hDEADBEEF);

    // R9 read trigger with R11 activity while pending
    ack_dly  = 30;
    rsp_word = 32'hCAFEF00D;
    rd_chk(1'b1, 8'h00, "R9 trigger read value");
    chk(xfer_busy == 1'b1, "R11 busy during read", {31'h0, xfer_busy}, 1);
    io_write(1'b1, 8'hCF);
    rd_chk(1'b1, 8'h01, "R11 status busy");
    reg_chk(8'hF4, 8'hEF, "R11 stale data byte");
    io_write(1'b1, 8'h55);
    reg_wr(8'hF0, 8'h99);
    wait_idle();
    chk(ack_cnt == 2, "R11 no extra transfer", ack_cnt, 2);
    chk(cap_we == 1'b0, "R9 read direction", {31'h0, cap_we}, 0);
    reg_chk(8'hF4, 8'h0D, "R9 loaded byte0");
    reg_chk(8'hF5, 8'hF0, "R9 loaded byte1");
    reg_chk(8'hF6, 8'hFE, "R9 loaded byte2");
    reg_chk(8'hF7, 8'hCA, "R9 loaded byte3");
    reg_chk(8'hF0, 8'h12, "R11 address write ignored");

    // R6 enable
    ack_dly = 2;
    reg_wr(8'h30, 8'h00);
    reg_wr(8'hFE, 8'hCF);
    repeat (5) @(negedge clk);
    chk(!xfer_busy && ack_cnt == 2, "R6 disabled trigger", ack_cnt, 2);
    reg_chk(8'h30, 8'h00, "R6 enable readback");
    reg_wr(8'h30, 8'h01);

    // R10 length
    reg_wr(8'hF8, 8'h03);
    reg_wr(8'hFE, 8'hCF);
    repeat (5) @(negedge clk);
    chk(!xfer_busy && ack_cnt == 2, "R10 wrong length", ack_cnt, 2);
    reg_wr(8'hF8, 8'h02);
    reg_wr(8'hFE, 8'hCF);
    wait_idle();
    chk(ack_cnt == 3, "R10 word length", ack_cnt, 3);

    // R5 device select
    reg_wr(8'h07, 8'h01);
    reg_chk(8'hF0, 8'hFF, "R5 other device read");
    io_write(1'b1, 8'h99);
    reg_chk(8'h07, 8'h01, "R5 device number");
    reg_wr(8'h07, 8'h0D);
    reg_chk(8'hF0, 8'h12, "R5 write ignored");

    // R3 relock, R2 broken key
    io_write(1'b0, 8'hAA);
    rd_chk(1'b0, 8'hFF, "R3 relocked index");
    rd_chk(1'b1, 8'hFF, "R3 relocked data");
    io_write(1'b1, 8'h77);
    io_write(1'b0, 8'hA5);
    io_write(1'b0, 8'h07);
    io_write(1'b0, 8'hA5);
    rd_chk(1'b0, 8'hFF, "R2 broken key stays locked");
    io_write(1'b0, 8'hA5);
    rd_chk(1'b0, 8'hF0, "R2 index kept");
    reg_chk(8'h07, 8'h0D, "R3 locked write ignored");

    // reset again
    do_reset();
    rd_chk(1'b0, 8'hFF, "R1 relocked by reset");
    chk(bus_addr == 32'h0, "R1 address cleared", bus_addr, 32'h0);

    finish_run();
  end
endmodule